// File: doc/BRIEF.md
# DDR2 Bank State and Command Legality Checker

This block sits beside a DDR2-style command bus and follows every command that is issued on it. For each bank it keeps whether a row is open and which row that is. It checks each incoming command against that state and against three minimum delays: activate-to-column, precharge recovery and mode-register recovery. Any command that breaks a rule raises a one-cycle error pulse with a two-bit cause code, and the tracked state is left as it was, so one bad command does not corrupt the rest of the trace.

Column commands may arrive early by the additive latency, because the memory registers them internally that many cycles later. Address bit 10 selects auto-precharge on a READ or WRITE and all-bank precharge on a PRECHARGE. Each bank also has a ready flag that shows when an ACTIVATE to it would be accepted.

The delays are parameters: TRCD, TRP and TMRD in cycles, AL in cycles, and BURST_LEN in beats at two beats per clock. All delays are counted from the cycle in which the command is presented.

Top module: `ddr_bank_checker`

## Requirements
- R1: In the cycle after reset is released, every bank reads idle (bankOpen = 0), every bankReady is 1, and errPulse is 0. No delay is pending.
- R2: LOAD MODE (cmdIn = 1) is accepted only when every bank is idle. If any bank has an open row, the result is error code 0.
- R3: An accepted ACTIVATE (cmdIn = 2) sets bankOpen for bank bankSel and stores addr as that bank's row on openRow[bankSel*ADDR_W +: ADDR_W]. bankReady for that bank then drops.
- R4: An ACTIVATE to a bank that already has an open row gives error code 1.
- R5: A READ (cmdIn = 3) or WRITE (cmdIn = 4) to a bank with no open row gives error code 2.
- R6: A READ or WRITE is accepted when it is presented TRCD−AL or more cycles after the ACTIVATE of its bank. If it comes earlier, the result is error code 3.
- R7: An accepted READ or WRITE with addr[10] = 1 closes its bank in the next cycle. That bank stays not ready until AL + BURST_LEN/2 + TRP cycles after the command. With addr[10] = 0 the row stays open.
- R8: PRECHARGE (cmdIn = 5) with addr[10] = 0 closes bank bankSel, and with addr[10] = 1 it closes every open bank. A bank that this closes accepts ACTIVATE TRP cycles later. An ACTIVATE issued earlier gives error code 3. PRECHARGE to an idle bank has no effect.
- R9: After an accepted LOAD MODE, any non-NOP command in the next TMRD−1 cycles gives error code 3. A LOAD MODE while any bank still has precharge recovery pending also gives code 3.
- R10: An error raises errPulse for exactly the cycle after the offending command, and bankOpen and openRow stay unchanged. The causes are checked in this order: recovery from a mode load first (code 3), then the bank-state rule (codes 0, 1, 2), then the other delays (code 3).
- R11: NOP (cmdIn = 0) and the unused codes 6 and 7 change nothing and never raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdIn | input | 3 | Decoded command: 0 NOP, 1 LOAD MODE, 2 ACTIVATE, 3 READ, 4 WRITE, 5 PRECHARGE |
| bankSel | input | $clog2(NUM_BANKS) | Bank address |
| addr | input | ADDR_W | Row or column address; bit 10 selects auto-precharge or all-bank precharge |
| bankOpen | output | NUM_BANKS | One bit per bank, high while that bank holds an open row |
| openRow | output | NUM_BANKS*ADDR_W | Row held by each bank, bank 0 in the low bits |
| bankReady | output | NUM_BANKS | One bit per bank, high when the bank is idle and its precharge recovery is over |
| errPulse | output | 1 | High for one cycle after an illegal command |
| errCode | output | 2 | Cause of the error: 0 mode load with a bank open, 1 activate to an open bank, 2 access to an idle bank, 3 timing |

## Verification
The assertions assume that exactly one decoded command is presented per cycle and that cmdIn, bankSel and addr carry known values whenever reset is low. They also assume a power-of-two bank count, so every bankSel value names a real bank. The stimulus changes all inputs only on the falling edge. It uses every bank address and the full address range, and it includes the two reserved command codes, so the properties see both legal and illegal commands against every kind of bank state.

// File: rtl/bank_chk_pkg.sv
package bank_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MODE = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_RD   = 3'd3,
    CMD_WR   = 3'd4,
    CMD_PRE  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_MODE_OPEN   = 2'd0,
    ERR_ACT_OPEN    = 2'd1,
    ERR_IDLE_ACCESS = 2'd2,
    ERR_TIMING      = 2'd3
  } err_e;

  // strobes from the control decoder to the state datapath
  typedef struct packed {
    logic doAct;
    logic doAccess;
    logic autoPre;
    logic doPre;
    logic preAll;
    logic doMode;
    logic errFire;
    err_e errCode;
  } strobe_t;

endpackage

// File: rtl/bank_chk_ctrl.sv
module bank_chk_ctrl
  import bank_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic [2:0]           cmdIn,
  input  logic [BA_W-1:0]      bankSel,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] rcdMet,
  input  logic [NUM_BANKS-1:0] rpDone,
  input  logic                 mrdBusy,
  output strobe_t              stb
);

  logic selOpen, selRcd, selRp;

  assign selOpen = bankOpen[bankSel];
  assign selRcd  = rcdMet[bankSel];
  assign selRp   = rpDone[bankSel];

  always_comb begin
    stb = '0;
    case (cmdIn)
      CMD_MODE: begin
        if (mrdBusy) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else if (|bankOpen) begin
          stb.errFire = 1'b1; stb.errCode = ERR_MODE_OPEN;
        end else if (!(&rpDone)) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else begin
          stb.doMode = 1'b1;
        end
      end
      CMD_ACT: begin
        if (mrdBusy) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else if (selOpen) begin
          stb.errFire = 1'b1; stb.errCode = ERR_ACT_OPEN;
        end else if (!selRp) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else begin
          stb.doAct = 1'b1;
        end
      end
      CMD_RD, CMD_WR: begin
        if (mrdBusy) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else if (!selOpen) begin
          stb.errFire = 1'b1; stb.errCode = ERR_IDLE_ACCESS;
        end else if (!selRcd) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else begin
          stb.doAccess = 1'b1;
          stb.autoPre  = a10;
        end
      end
      CMD_PRE: begin
        if (mrdBusy) begin
          stb.errFire = 1'b1; stb.errCode = ERR_TIMING;
        end else begin
          stb.doPre  = 1'b1;
          stb.preAll = a10;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bank_chk_dpath.sv
module bank_chk_dpath
  import bank_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 14,
  parameter int TRCD      = 4,
  parameter int TRP       = 3,
  parameter int TMRD      = 2,
  parameter int AL        = 2,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     stb,
  input  logic [BA_W-1:0]             bankSel,
  input  logic [ADDR_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]        bankOpen,
  output logic [NUM_BANKS*ADDR_W-1:0] openRow,
  output logic [NUM_BANKS-1:0]        bankReady,
  output logic [NUM_BANKS-1:0]        rcdMet,
  output logic [NUM_BANKS-1:0]        rpDone,
  output logic                        mrdBusy,
  output logic                        errPulse,
  output logic [1:0]                  errCode
);

  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(TRCD - 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(TRP - 1);
  localparam logic [CNT_W-1:0] AP_LOAD  = CNT_W'(AL + BURST_LEN / 2 + TRP - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(TMRD - 1);
  localparam logic [CNT_W-1:0] AL_LIM   = CNT_W'(AL);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              isSel;
    logic              openQ;
    logic [ADDR_W-1:0] rowQ;
    logic [CNT_W-1:0]  rcdQ;
    logic [CNT_W-1:0]  rpQ;

    assign isSel = (bankSel == BA_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        openQ <= 1'b0;
        rowQ  <= '0;
        rcdQ  <= '0;
        rpQ   <= '0;
      end else begin
        if (rcdQ != '0) rcdQ <= rcdQ - ONE;
        if (rpQ != '0)  rpQ  <= rpQ - ONE;
        if (stb.doAct && isSel) begin
          openQ <= 1'b1;
          rowQ  <= addr;
          rcdQ  <= RCD_LOAD;
        end else if (stb.doAccess && stb.autoPre && isSel) begin
          openQ <= 1'b0;
          rpQ   <= AP_LOAD;
        end else if (stb.doPre && (stb.preAll || isSel) && openQ) begin
          openQ <= 1'b0;
          rpQ   <= RP_LOAD;
        end
      end
    end

    assign bankOpen[g]                  = openQ;
    assign openRow[g*ADDR_W +: ADDR_W]  = rowQ;
    assign rcdMet[g]                    = (rcdQ <= AL_LIM);
    assign rpDone[g]                    = (rpQ == '0);
    assign bankReady[g]                 = !openQ && (rpQ == '0);
  end

  logic [CNT_W-1:0] mrdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      mrdQ     <= '0;
      errPulse <= 1'b0;
      errCode  <= '0;
    end else begin
      if (stb.doMode)      mrdQ <= MRD_LOAD;
      else if (mrdQ != '0) mrdQ <= mrdQ - ONE;
      errPulse <= stb.errFire;
      errCode  <= stb.errCode;
    end
  end

  assign mrdBusy = (mrdQ != '0);

endmodule

// File: rtl/ddr_bank_checker.sv
module ddr_bank_checker
  import bank_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 14,
  parameter int TRCD      = 4,
  parameter int TRP       = 3,
  parameter int TMRD      = 2,
  parameter int AL        = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  cmdIn,
  input  logic [BA_W-1:0]             bankSel,
  input  logic [ADDR_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]        bankOpen,
  output logic [NUM_BANKS*ADDR_W-1:0] openRow,
  output logic [NUM_BANKS-1:0]        bankReady,
  output logic                        errPulse,
  output logic [1:0]                  errCode
);

  localparam int MAX_LOAD = AL + BURST_LEN / 2 + TRP + TRCD + TMRD;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  strobe_t              stb;
  logic [NUM_BANKS-1:0] rcdMet;
  logic [NUM_BANKS-1:0] rpDone;
  logic                 mrdBusy;

  bank_chk_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W)
  ) u_ctrl (
    .cmdIn   (cmdIn),
    .bankSel (bankSel),
    .a10     (addr[10]),
    .bankOpen(bankOpen),
    .rcdMet  (rcdMet),
    .rpDone  (rpDone),
    .mrdBusy (mrdBusy),
    .stb     (stb)
  );

  bank_chk_dpath #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W),
    .ADDR_W   (ADDR_W),
    .TRCD     (TRCD),
    .TRP      (TRP),
    .TMRD     (TMRD),
    .AL       (AL),
    .BURST_LEN(BURST_LEN),
    .CNT_W    (CNT_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .bankSel  (bankSel),
    .addr     (addr),
    .bankOpen (bankOpen),
    .openRow  (openRow),
    .bankReady(bankReady),
    .rcdMet   (rcdMet),
    .rpDone   (rpDone),
    .mrdBusy  (mrdBusy),
    .errPulse (errPulse),
    .errCode  (errCode)
  );

endmodule

// File: rtl/bank_chk_sva.sv
module bank_chk_sva
  import bank_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 14
) (
  input logic                        clk,
  input logic                        rst,
  input logic [2:0]                  cmdIn,
  input logic [BA_W-1:0]             bankSel,
  input logic [ADDR_W-1:0]           addr,
  input logic [NUM_BANKS-1:0]        bankOpen,
  input logic [NUM_BANKS*ADDR_W-1:0] openRow,
  input logic [NUM_BANKS-1:0]        bankReady,
  input logic                        errPulse,
  input logic [1:0]                  errCode,
  input logic                        mrdBusy
);

  // R1: reset leaves every bank idle and ready, with no error
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (bankOpen == '0 && bankReady == '1 && !errPulse));

  // R2: mode load with an open bank
  a_r2_mode_open: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_MODE && |bankOpen && !mrdBusy)
      |=> (errPulse && errCode == ERR_MODE_OPEN));

  // R3: accepted activate opens the bank with the given row
  a_r3_act_opens: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_ACT && bankReady[bankSel] && !mrdBusy)
      |=> (bankOpen[$past(bankSel)] && !errPulse));

  a_r3_act_row: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_ACT && bankReady[bankSel] && !mrdBusy)
      |=> (openRow[int'($past(bankSel))*ADDR_W +: ADDR_W] == $past(addr)));

  // R4: activate to an open bank
  a_r4_act_open: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_ACT && bankOpen[bankSel] && !mrdBusy)
      |=> (errPulse && errCode == ERR_ACT_OPEN));

  // R5: column access to an idle bank
  a_r5_idle_access: assert property (@(posedge clk) disable iff (rst)
    ((cmdIn == CMD_RD || cmdIn == CMD_WR) && !bankOpen[bankSel] && !mrdBusy)
      |=> (errPulse && errCode == ERR_IDLE_ACCESS));

  // R10: an error leaves the tracked bank state untouched
  a_r10_err_keeps_state: assert property (@(posedge clk) disable iff (rst)
    errPulse |-> ($stable(bankOpen) && $stable(openRow)));

  // R11: idle and reserved codes never raise an error
  a_r11_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_NOP || cmdIn == 3'd6 || cmdIn == 3'd7)
      |=> (!errPulse && $stable(bankOpen) && $stable(openRow)));

endmodule

bind ddr_bank_checker bank_chk_sva #(
  .NUM_BANKS(NUM_BANKS),
  .BA_W     (BA_W),
  .ADDR_W   (ADDR_W)
) u_sva (.*);

// File: tb/ddr_bank_checker_tb.sv
`timescale 1ns/1ps
module ddr_bank_checker_tb;
  import bank_chk_pkg::*;

  localparam int NB   = 4;
  localparam int AW   = 14;
  localparam int TRCD = 4;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int AL   = 2;
  localparam int BL   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      cmdIn = 3'd0;
  logic [1:0]      bankSel = 2'd0;
  logic [AW-1:0]   addr = '0;
  logic [NB-1:0]   bankOpen;
  logic [NB*AW-1:0] openRow;
  logic [NB-1:0]   bankReady;
  logic            errPulse;
  logic [1:0]      errCode;

  ddr_bank_checker u_dut (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .bankSel(bankSel), .addr(addr),
    .bankOpen(bankOpen), .openRow(openRow), .bankReady(bankReady),
    .errPulse(errPulse), .errCode(errCode)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mOpen[NB];
  int mRow[NB];
  int mRcd[NB];
  int mRp[NB];
  int mMrd;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < NB; b++) begin
      mOpen[b] = 0; mRow[b] = 0; mRcd[b] = 0; mRp[b] = 0;
    end
    mMrd = 0;
  endtask

  // computes expected error from the requirements, then advances the model
  task automatic predict(input int c, input int ba, input int ad,
                         output int eErr, output int eCode, output string tag);
    int a10;
    int anyOpen;
    int anyRp;
    a10 = (ad >> 10) & 1;
    anyOpen = 0; anyRp = 0;
    for (int b = 0; b < NB; b++) begin
      if (mOpen[b] != 0) anyOpen = 1;
      if (mRp[b] != 0) anyRp = 1;
    end
    eErr = 0; eCode = 0; tag = "R11";
    if (c >= 1 && c <= 5 && mMrd != 0) begin
      eErr = 1; eCode = 3; tag = "R9";
    end else if (c == 1) begin
      tag = "R2";
      if (anyOpen != 0) begin eErr = 1; eCode = 0; end
      else if (anyRp != 0) begin eErr = 1; eCode = 3; tag = "R9"; end
    end else if (c == 2) begin
      tag = "R3";
      if (mOpen[ba] != 0) begin eErr = 1; eCode = 1; tag = "R4"; end
      else if (mRp[ba] != 0) begin eErr = 1; eCode = 3; tag = "R8"; end
    end else if (c == 3 || c == 4) begin
      tag = "R6";
      if (mOpen[ba] == 0) begin eErr = 1; eCode = 2; tag = "R5"; end
      else if (mRcd[ba] > AL) begin eErr = 1; eCode = 3; end
    end else if (c == 5) begin
      tag = "R8";
    end
    for (int b = 0; b < NB; b++) begin
      if (mRcd[b] > 0) mRcd[b]--;
      if (mRp[b] > 0) mRp[b]--;
    end
    if (mMrd > 0) mMrd--;
    if (eErr == 0) begin
      case (c)
        1: mMrd = TMRD - 1;
        2: begin mOpen[ba] = 1; mRow[ba] = ad; mRcd[ba] = TRCD - 1; end
        3, 4: if (a10 != 0) begin
          mOpen[ba] = 0; mRp[ba] = AL + BL / 2 + TRP - 1;
        end
        5: for (int b = 0; b < NB; b++) begin
          if ((a10 != 0 || b == ba) && mOpen[b] != 0) begin
            mOpen[b] = 0; mRp[b] = TRP - 1;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic compareAll(int eErr, int eCode, string tag);
    chk(tag, int'(errPulse), eErr, "errPulse");
    if (eErr != 0) chk("R10", int'(errCode), eCode, "errCode");
    for (int b = 0; b < NB; b++) begin
      chk("R3", int'(bankOpen[b]), mOpen[b], "bankOpen");
      chk("R7", int'(bankReady[b]), (mOpen[b] == 0 && mRp[b] == 0) ? 1 : 0, "bankReady");
      if (mOpen[b] != 0)
        chk("R3", int'(openRow[b*AW +: AW]), mRow[b], "openRow");
    end
  endtask

  // inputs change at the falling edge; outputs are sampled at the next one
  task automatic doCycle(int c, int ba, int ad);
    int eErr, eCode;
    string tag;
    cmdIn = c[2:0]; bankSel = ba[1:0]; addr = ad[AW-1:0];
    predict(c, ba, ad, eErr, eCode, tag);
    @(posedge clk);
    @(negedge clk);
    compareAll(eErr, eCode, tag);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) doCycle(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmdIn = 3'd0;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(bankOpen), 0, "bankOpen");
    chk("R1", int'(bankReady), 15, "bankReady");
    chk("R1", int'(errPulse), 0, "errPulse");

    // R9: mode load then early command
    doCycle(1, 2, 0);
    chk("R2", int'(errPulse), 0, "mode load idle");
    doCycle(2, 0, 14'h1234);
    chk("R9", int'(errPulse), 1, "act inside mode recovery");
    chk("R9", int'(errCode), 3, "code");
    doCycle(2, 0, 14'h1234);
    chk("R3", int'(openRow[0 +: AW]), 14'h1234, "row stored");

    // R6: read one cycle after activate is too early, two is fine (TRCD-AL=2)
    doCycle(3, 0, 14'h0010);
    chk("R6", int'(errCode), 3, "early read code");
    doCycle(3, 0, 14'h0010);
    chk("R6", int'(errPulse), 0, "read at tRCD-AL");
    chk("R7", int'(bankOpen[0]), 1, "row stays open a10 low");

    // R4 / R10: second activate rejected, row kept
    doCycle(2, 0, 14'h0777);
    chk("R4", int'(errCode), 1, "act open code");
    chk("R10", int'(openRow[0 +: AW]), 14'h1234, "row unchanged");

    // R5: read to idle bank
    doCycle(3, 1, 0);
    chk("R5", int'(errCode), 2, "idle access code");

    // R2: mode load with open bank
    doCycle(1, 0, 0);
    chk("R2", int'(errCode), 0, "mode open code");

    // R7: write with auto-precharge
    doCycle(4, 0, 14'h0400);
    chk("R7", int'(bankOpen[0]), 0, "closed after auto precharge");
    nops(2);
    doCycle(2, 0, 14'h0001);
    chk("R7", int'(errCode), 3, "act during auto precharge");
    nops(2);
    chk("R7", int'(bankReady[0]), 0, "not ready one cycle early");
    nops(1);
    chk("R7", int'(bankReady[0]), 1, "ready at AL+BL/2+tRP");

    // R8: all-bank precharge and recovery
    doCycle(2, 1, 14'h0011);
    doCycle(2, 2, 14'h0022);
    doCycle(5, 3, 14'h0400);
    chk("R8", int'(bankOpen), 0, "all banks closed");
    doCycle(2, 1, 14'h0033);
    chk("R8", int'(errCode), 3, "act during tRP");
    nops(1);
    doCycle(2, 1, 14'h0033);
    chk("R8", int'(errPulse), 0, "act at tRP");

    // R11: reserved codes ignored
    doCycle(7, 1, 14'h3fff);
    doCycle(6, 2, 14'h2aaa);
    chk("R11", int'(bankOpen), 2, "reserved no effect");
    chk("R11", int'(openRow[AW +: AW]), 14'h0033, "row kept");

    // random traffic, weighted toward column commands and precharges
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      r = int'($urandom(seed) % 16);
      seed = seed + 1;
      if (r < 3) c = 0;
      else if (r < 4) c = 1;
      else if (r < 7) c = 2;
      else if (r < 11) c = 3 + (r & 1);
      else if (r < 14) c = 5;
      else c = 6 + (r & 1);
      doCycle(c, int'($urandom % NB), int'($urandom % (1 << AW)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule